// File: doc/BRIEF.md
# Audio Sample Clock-Domain Handshake

This block carries a stereo pair of 16-bit signed audio samples from a fast system clock domain into an unrelated audio clock domain. On the system side a new pair is latched into a holding register. The source then flips a single request bit. A two-flop synchronizer brings that bit into the audio domain. When the synchronized bit shows a new value, the audio side copies the held pair, widens each channel to 17 bits and raises a one-cycle strobe. It then returns the request value as an acknowledge, which crosses back through its own two-flop synchronizer.

The data bus never passes through per-bit synchronizers. It stays frozen while a transfer is in flight, so the audio side always reads a coherent word. Samples arrive far less often than either clock ticks, so one outstanding transfer is enough. A pair that arrives while a transfer is outstanding is parked in a pending register. A later arrival replaces it, and only the newest parked pair goes out once the acknowledge returns.

Top module: `audio_sample_cdc`

## Requirements
- R1: While each domain's active-high reset is held, and on the first cycles after release, `aud_left` and `aud_right` read zero and `aud_strobe` is low.
- R2: Each output channel is the 16-bit two's-complement input sample widened to 17 bits by copying bit 15 into bit 16. For example, 16'hFFFF appears as 17'h1FFFF and 16'h7FFF appears as 17'h07FFF.
- R3: Every pair that is sent on an idle block appears on the outputs exactly once, in order, with `aud_strobe` high for exactly one audio cycle in the cycle the outputs take the new pair.
- R4: The held sample pair seen by the audio domain does not change while the request and the synchronized acknowledge differ.
- R5: The request bit toggles only when the synchronized acknowledge equals it, so at most one transfer is outstanding.
- R6: If several pairs arrive while a transfer is outstanding, only the last of them is delivered after the acknowledge returns. The pairs in between never appear on the outputs.
- R7: When `aud_strobe` is low, `aud_left` and `aud_right` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System (source) clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| smp_valid | input | 1 | One-cycle pulse: a new sample pair is on `smp_left`/`smp_right` |
| smp_left | input | 16 | Left sample, signed two's complement |
| smp_right | input | 16 | Right sample, signed two's complement |
| clk_aud | input | 1 | Audio (destination) clock |
| rst_aud | input | 1 | Synchronous active-high reset, audio domain |
| aud_left | output | 17 | Widened left sample, audio domain |
| aud_right | output | 17 | Widened right sample, audio domain |
| aud_strobe | output | 1 | One-cycle pulse when the output pair is updated |

## Verification
The assertions assume that the two resets are released together and that each held pair stays put for the whole round trip. They also assume that no clock stalls, so a toggle always comes back. The data-equality check on the audio side reads the held pair from the previous audio edge. It relies on that pair staying frozen for the whole round trip. The stimulus drives samples only on system falling edges, as single-cycle pulses. Between single transfers it waits until the scoreboard has drained and a full acknowledge round trip has passed. Only the overwrite burst deliberately presents pairs while a transfer is outstanding.

// File: rtl/aucdc_pkg.sv
package aucdc_pkg;

    localparam int SMP_W = 16;
    localparam int EXT_W = SMP_W + 1;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [EXT_W-1:0] ext_t;

    typedef struct packed {
        smp_t left;
        smp_t right;
    } pair_t;

    typedef struct packed {
        ext_t left;
        ext_t right;
    } ext_pair_t;

    // what the source does in a given system cycle
    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SEND_NEW,
        ACT_SEND_PEND,
        ACT_PARK
    } src_act_e;

    function automatic ext_t widen(smp_t s);
        return {s[SMP_W-1], s};
    endfunction

endpackage

// File: rtl/aucdc_sync.sv
module aucdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aucdc_src.sv
module aucdc_src
    import aucdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pair_t in_pair,
    input  logic  ack_s,
    output logic  req,
    output pair_t held
);
    logic     req_q;
    pair_t    held_q;
    pair_t    park_q;
    logic     park_vld_q;
    logic     idle;
    src_act_e act;

    assign idle = (req_q == ack_s);

    always_comb begin
        if (idle && in_valid)        act = ACT_SEND_NEW;
        else if (idle && park_vld_q) act = ACT_SEND_PEND;
        else if (in_valid)           act = ACT_PARK;
        else                         act = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            held_q     <= '0;
            park_q     <= '0;
            park_vld_q <= 1'b0;
        end else begin
            case (act)
                ACT_SEND_NEW: begin
                    held_q     <= in_pair;
                    req_q      <= ~req_q;
                    park_vld_q <= 1'b0;
                end
                ACT_SEND_PEND: begin
                    held_q     <= park_q;
                    req_q      <= ~req_q;
                    park_vld_q <= 1'b0;
                end
                ACT_PARK: begin
                    park_q     <= in_pair;
                    park_vld_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign req  = req_q;
    assign held = held_q;
endmodule

// File: rtl/aucdc_dst.sv
module aucdc_dst
    import aucdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_s,
    input  pair_t     held,
    output ext_pair_t out_pair,
    output logic      strobe,
    output logic      ack
);
    logic      seen_q;
    ext_pair_t out_q;
    logic      strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= 1'b0;
            out_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (req_s != seen_q) begin
                seen_q        <= req_s;
                out_q.left    <= widen(held.left);
                out_q.right   <= widen(held.right);
                strobe_q      <= 1'b1;
            end
        end
    end

    assign out_pair = out_q;
    assign strobe   = strobe_q;
    assign ack      = seen_q;
endmodule

// File: rtl/audio_sample_cdc.sv
module audio_sample_cdc
    import aucdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_sys,
    input  logic             rst_sys,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             clk_aud,
    input  logic             rst_aud,
    output logic [EXT_W-1:0] aud_left,
    output logic [EXT_W-1:0] aud_right,
    output logic             aud_strobe
);
    pair_t     in_pair;
    pair_t     held_pair;
    ext_pair_t out_pair;
    logic      req_tog;
    logic      ack_tog;
    logic      req_in_aud;
    logic      ack_in_sys;

    assign in_pair.left  = smp_left;
    assign in_pair.right = smp_right;

    aucdc_src u_src (
        .clk      (clk_sys),
        .rst      (rst_sys),
        .in_valid (smp_valid),
        .in_pair  (in_pair),
        .ack_s    (ack_in_sys),
        .req      (req_tog),
        .held     (held_pair)
    );

    aucdc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk_aud),
        .rst (rst_aud),
        .d   (req_tog),
        .q   (req_in_aud)
    );

    aucdc_dst u_dst (
        .clk      (clk_aud),
        .rst      (rst_aud),
        .req_s    (req_in_aud),
        .held     (held_pair),
        .out_pair (out_pair),
        .strobe   (aud_strobe),
        .ack      (ack_tog)
    );

    aucdc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk_sys),
        .rst (rst_sys),
        .d   (ack_tog),
        .q   (ack_in_sys)
    );

    assign aud_left  = out_pair.left;
    assign aud_right = out_pair.right;
endmodule

// File: rtl/audio_sample_cdc_chk.sv
module audio_sample_cdc_chk
    import aucdc_pkg::*;
(
    input logic             clk_sys,
    input logic             rst_sys,
    input logic             clk_aud,
    input logic             rst_aud,
    input logic             req_tog,
    input logic             ack_in_sys,
    input logic             ack_tog,
    input pair_t            held_pair,
    input logic [EXT_W-1:0] aud_left,
    input logic [EXT_W-1:0] aud_right,
    input logic             aud_strobe
);
    // R4
    held_stable_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (req_tog != ack_in_sys) |=> $stable(held_pair));

    // R5
    req_wait_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (req_tog != ack_in_sys) |=> $stable(req_tog));

    // R3
    strobe_single_chk: assert property (@(posedge clk_aud) disable iff (rst_aud)
        aud_strobe |=> !aud_strobe);

    // R3
    ack_strobe_chk: assert property (@(posedge clk_aud) disable iff (rst_aud)
        (ack_tog != $past(ack_tog)) |-> aud_strobe);

    // R7
    hold_out_chk: assert property (@(posedge clk_aud) disable iff (rst_aud)
        !aud_strobe |-> ($stable(aud_left) && $stable(aud_right)));

    // R2
    widen_chk: assert property (@(posedge clk_aud) disable iff (rst_aud)
        aud_strobe |-> (aud_left  == widen($past(held_pair.left)) &&
                        aud_right == widen($past(held_pair.right))));
endmodule

bind audio_sample_cdc audio_sample_cdc_chk u_chk (
    .clk_sys    (clk_sys),
    .rst_sys    (rst_sys),
    .clk_aud    (clk_aud),
    .rst_aud    (rst_aud),
    .req_tog    (req_tog),
    .ack_in_sys (ack_in_sys),
    .ack_tog    (ack_tog),
    .held_pair  (held_pair),
    .aud_left   (aud_left),
    .aud_right  (aud_right),
    .aud_strobe (aud_strobe)
);

// File: tb/sim_audio_sample_cdc.sv
module sim_audio_sample_cdc;
    localparam time SYS_PERIOD = 10ns;
    localparam time AUD_PERIOD = 37ns;

    logic        clk_sys = 1'b0;
    logic        clk_aud = 1'b0;
    logic        rst_sys = 1'b1;
    logic        rst_aud = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic [16:0] aud_left;
    logic [16:0] aud_right;
    logic        aud_strobe;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int pushed = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(SYS_PERIOD/2) clk_sys = ~clk_sys;
    always #(AUD_PERIOD/2) clk_aud = ~clk_aud;

    audio_sample_cdc u0 (
        .clk_sys    (clk_sys),
        .rst_sys    (rst_sys),
        .smp_valid  (smp_valid),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .clk_aud    (clk_aud),
        .rst_aud    (rst_aud),
        .aud_left   (aud_left),
        .aud_right  (aud_right),
        .aud_strobe (aud_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] ext16(logic [15:0] s);
        return {s[15], s};
    endfunction

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk_aud) begin
        if (!rst_aud && aud_strobe) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected strobe", {aud_left, aud_right}, '0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({aud_left, aud_right} == {ext16(e[31:16]), ext16(e[15:0])},
                      t, "delivered pair", {aud_left, aud_right},
                      {ext16(e[31:16]), ext16(e[15:0])});
            end
        end
    end

    task automatic pulse(input logic [15:0] l, input logic [15:0] r,
                         input bit expect_it, input string tag);
        @(negedge clk_sys);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        if (expect_it) begin
            exp_q.push_back({l, r});
            tag_q.push_back(tag);
            pushed++;
        end
        @(negedge clk_sys);
        smp_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk_sys);
        repeat (40) @(negedge clk_sys);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_sys);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (6) @(negedge clk_aud);
        // R1: state while reset is held
        check(aud_strobe == 1'b0, "R1", "strobe in reset", {33'b0, aud_strobe}, '0);
        check({aud_left, aud_right} == '0, "R1", "outputs in reset", {aud_left, aud_right}, '0);
        @(negedge clk_sys);
        rst_sys = 1'b0;
        rst_aud = 1'b0;
        repeat (5) @(negedge clk_aud);
        // R1: state after release with no input
        check(aud_strobe == 1'b0, "R1", "strobe after reset", {33'b0, aud_strobe}, '0);
        check({aud_left, aud_right} == '0, "R1", "outputs after reset", {aud_left, aud_right}, '0);

        // R2/R3: single transfers of distinct patterns
        pulse(16'h1234, 16'hFFFB, 1'b1, "R3"); drain();
        pulse(16'h7FFF, 16'h8000, 1'b1, "R2"); drain();
        pulse(16'hFFFF, 16'h0000, 1'b1, "R2"); drain();
        pulse(16'h5A5A, 16'hA5A5, 1'b1, "R3"); drain();
        // R2: explicit boundary values of the last widened pair
        pulse(16'h8001, 16'h7FFE, 1'b1, "R2"); drain();
        check(aud_left == 17'h18001, "R2", "negative widen", {17'b0, aud_left}, {17'b0, 17'h18001});
        check(aud_right == 17'h07FFE, "R2", "positive widen", {17'b0, aud_right}, {17'b0, 17'h07FFE});

        // R7: no input for a while, outputs hold and no strobe
        begin
            int s0;
            logic [33:0] o0;
            s0 = strobes;
            o0 = {aud_left, aud_right};
            repeat (60) @(negedge clk_sys);
            check(strobes == s0, "R7", "strobes while idle", 34'(strobes), 34'(s0));
            check({aud_left, aud_right} == o0, "R7", "outputs while idle", {aud_left, aud_right}, o0);
        end

        // R6: burst while busy; first goes, middle overwritten, last goes
        pulse(16'h0101, 16'h0202, 1'b1, "R6");
        pulse(16'h0303, 16'h0404, 1'b0, "R6");
        pulse(16'h0505, 16'h0606, 1'b0, "R6");
        pulse(16'h0707, 16'h0808, 1'b1, "R6");
        drain();
        check(aud_left == 17'h00707, "R6", "last pair kept", {17'b0, aud_left}, {17'b0, 17'h00707});

        // R3: every expected pair was delivered exactly once
        check(strobes == pushed, "R3", "strobe count", 34'(strobes), 34'(pushed));
        check(exp_q.size() == 0, "R3", "scoreboard empty", 34'(exp_q.size()), '0);
        finish_run();
    end
endmodule